// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block is the byte-wide register file behind a serial control port. The port logic hands it a decoded address, a write byte and separate write and read strobes. The block returns read data in the same cycle. It drives the committed control values that the rest of the chip uses.

The function registers sit at 0x08 to 0x2A. Those from 0x08 to 0x18 are double-buffered. A write there changes only a staging copy. Writing a set bit 0 to the commit address 0xFF moves every staged byte into its live copy on one clock edge, and the commit bit then drops by itself. The bytes from 0x19 to 0x2A have a single copy and act at once.

A port-setup byte at 0x00 carries two control bits, the bit-order select and the soft reset. Each is stored twice, mirrored across the nibbles, so the byte reads the same in either shift order. Two read-only bytes identify the device and its speed grade. Only a few critical registers take defaults on reset; the rest hold their contents through it.

Top module: `cfg_shadow_bank`

## Requirements
- R1: `rdata` is combinational and shows the addressed register while `rd_en` is high; with `rd_en` low it is 0x00.
- R2: A write to 0x08..0x18 is read back from the staging copy on the next cycle and leaves `act_q` unchanged.
- R3: A write to 0xFF with bit 0 set raises `commit_o` for exactly the following cycle, and 0xFF reads 0x01 during that cycle. At the end of that cycle every byte of 0x08..0x18 on `act_q` takes its staging value. Afterwards 0xFF reads 0x00. A write to 0xFF with bit 0 clear commits nothing.
- R4: A write to 0x19..0x2A appears on `act_q` on the next cycle.
- R5: At 0x00, bits 6, 5, 2 and 1 are writable, bits 4 and 3 read 1, and bits 7 and 0 read 0. `lsb_first_o` is the OR of bits 6 and 1.
- R6: A write to 0x00 with bit 5 or bit 2 set raises `soft_rst_o` for exactly the next cycle. At the end of that cycle, 0x00 returns to 0x18, the clock byte 0x09 returns to 0x01 in both copies, and the commit bit clears. Other registers keep their values.
- R7: 0x01 reads 0x0C and 0x02 reads 0x30 (grade code 2'b11 in bits 5:4); writes to them are ignored.
- R8: With `rst_n` low at a clock edge, 0x00 loads 0x18, both copies of 0x09 load 0x01 and the commit bit clears. Every other function register keeps its contents.
- R9: Byte k of `act_q` (bits 8k+7..8k) is the live value of address 0x08+k, and `dcs_en_o` is bit 0 of the live copy of 0x09.
- R10: Addresses 0x03..0x07 and 0x2B..0xFE read 0x00, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, combinational |
| act_q | output | 280 | Live copies of 0x08..0x2A, byte k = address 0x08+k |
| dcs_en_o | output | 1 | Duty-cycle stabilizer enable |
| lsb_first_o | output | 1 | LSB-first shift order select |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| commit_o | output | 1 | Commit cycle indicator |

## Verification
The hardest cases involve timing overlaps at the edge where the commit takes effect. In one, a new staging write lands on that same edge, and the live copy must take the old staged value. In another, a soft reset overlaps a pending commit. Neither can be set up with a single write. The stimulus first fills every register, then issues back-to-back writes around the commit cycle. Long stretches of mixed writes follow, to all addresses including 0x00 and 0xFF, with a behavioural model checked on every clock. A hard reset is applied after all registers hold known patterns, so that values retained through reset can be seen.

// File: rtl/cfgbank_pkg.sv
// Shared types and field positions for the configuration register bank.
// Assumes byte-wide registers throughout.
package cfgbank_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Bit positions in the port-setup byte; the nibbles mirror each other.
    localparam int PC_LSB_HI  = 6;
    localparam int PC_SRST_HI = 5;
    localparam int PC_SRST_LO = 2;
    localparam int PC_LSB_LO  = 1;

    // Constant bits of the port-setup byte (also its reset image).
    localparam byte_t PC_FIXED = 8'h18;

    typedef struct packed {
        logic lsb_hi;
        logic srst_hi;
        logic srst_lo;
        logic lsb_lo;
    } portcfg_t;

    // Build the readable image of the port-setup byte.
    function automatic byte_t portcfg_image(input portcfg_t pc);
        byte_t b;
        b             = PC_FIXED;
        b[PC_LSB_HI]  = pc.lsb_hi;
        b[PC_SRST_HI] = pc.srst_hi;
        b[PC_SRST_LO] = pc.srst_lo;
        b[PC_LSB_LO]  = pc.lsb_lo;
        return b;
    endfunction

    // Pick the writable fields out of a write byte.
    function automatic portcfg_t portcfg_fields(input byte_t b);
        portcfg_t pc;
        pc.lsb_hi  = b[PC_LSB_HI];
        pc.srst_hi = b[PC_SRST_HI];
        pc.srst_lo = b[PC_SRST_LO];
        pc.lsb_lo  = b[PC_LSB_LO];
        return pc;
    endfunction

endpackage

// File: rtl/cfg_port_ctrl.sv
// Port-setup register: holds the mirrored bit-order and soft-reset bits.
// Assumes wr_hit is already qualified by address. The soft-reset pulse
// clears the whole register one cycle after it is written.
module cfg_port_ctrl
    import cfgbank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_hit,
    input  portcfg_t wr_fields,
    output byte_t    rd_image,
    output logic     lsb_first,
    output logic     soft_rst
);

    portcfg_t pc_q;

    // Load on write; hard or soft reset returns the default image.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            pc_q <= '0;
        end else if (wr_hit) begin
            pc_q <= wr_fields;
        end
    end

    assign soft_rst  = pc_q.srst_hi | pc_q.srst_lo;
    assign lsb_first = pc_q.lsb_hi | pc_q.lsb_lo;
    assign rd_image  = portcfg_image(pc_q);

    AST_SOFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst); // R6

    AST_SOFT_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (rd_image == PC_FIXED)); // R6

endmodule

// File: rtl/cfg_xfer_ctrl.sv
// Commit bit: set for exactly one cycle by a write with bit 0 high,
// then clears itself. Assumes wr_hit is already address-qualified.
module cfg_xfer_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic wr_hit,
    input  logic go,
    output logic commit
);

    logic xfer_q;

    // Self-clearing commit request.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            xfer_q <= 1'b0;
        end else begin
            xfer_q <= wr_hit && go;
        end
    end

    assign commit = xfer_q;

    AST_XFER_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !(wr_hit && go)) |=> !commit); // R3

endmodule

// File: rtl/cfg_func_byte.sv
// One function register. SHADOWED selects a staging plus live pair;
// otherwise the single copy is live. HAS_DEF marks a critical register
// that loads DEF_VAL on hard or soft reset; others keep contents.
module cfg_func_byte
    import cfgbank_pkg::*;
#(
    parameter bit    SHADOWED = 1'b1,
    parameter bit    HAS_DEF  = 1'b0,
    parameter byte_t DEF_VAL  = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  soft_rst,
    input  logic  wr_hit,
    input  byte_t wdata,
    input  logic  commit,
    output byte_t shd_o,
    output byte_t act_o
);

    byte_t shd_q;

    // Staging copy: written by the port, reloaded only if critical.
    always_ff @(posedge clk) begin
        if (HAS_DEF && (!rst_n || soft_rst)) begin
            shd_q <= DEF_VAL;
        end else if (wr_hit) begin
            shd_q <= wdata;
        end
    end

    assign shd_o = shd_q;

    generate
        if (SHADOWED) begin : g_pair
            byte_t act_q;

            // Live copy: takes the staged value on a commit cycle.
            always_ff @(posedge clk) begin
                if (HAS_DEF && (!rst_n || soft_rst)) begin
                    act_q <= DEF_VAL;
                end else if (commit) begin
                    act_q <= shd_q;
                end
            end

            assign act_o = act_q;

            AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!commit && !(HAS_DEF && soft_rst)) |=> $stable(act_q)); // R2

            AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
                (commit && !(HAS_DEF && soft_rst)) |=> (act_q == $past(shd_q))); // R3
        end else begin : g_single
            assign act_o = shd_q;
        end
    endgenerate

endmodule

// File: rtl/cfg_shadow_bank.sv
// Configuration register bank behind a serial control port.
// Assumes addr/wdata/strobes are decoded and stable for one cycle each.
// Reads are combinational; writes take effect at the clock edge.
module cfg_shadow_bank
    import cfgbank_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          FUNC_LO    = 8'h08,
    parameter int          FUNC_HI    = 8'h2A,
    parameter int          SHD_HI     = 8'h18,
    parameter int          CLK_ADDR   = 8'h09,
    parameter byte_t       CLK_DEF    = 8'h01,
    parameter int          ID_ADDR    = 8'h01,
    parameter int          GRADE_ADDR = 8'h02,
    parameter int          XFER_ADDR  = 8'hFF,
    parameter byte_t       CHIP_ID    = 8'h0C,
    parameter logic [1:0]  GRADE_CODE = 2'b11,
    localparam int         NFUNC      = FUNC_HI - FUNC_LO + 1,
    localparam int         CLK_IDX    = CLK_ADDR - FUNC_LO
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [BYTE_W-1:0]       rdata,
    output logic [NFUNC*BYTE_W-1:0] act_q,
    output logic                    dcs_en_o,
    output logic                    lsb_first_o,
    output logic                    soft_rst_o,
    output logic                    commit_o
);

    localparam logic [ADDR_W-1:0] A_PORT  = '0;
    localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(ID_ADDR);
    localparam logic [ADDR_W-1:0] A_GRADE = ADDR_W'(GRADE_ADDR);
    localparam logic [ADDR_W-1:0] A_XFER  = ADDR_W'(XFER_ADDR);
    localparam byte_t GRADE_IMG = byte_t'({GRADE_CODE, 4'b0000});

    byte_t port_img;
    byte_t shd_arr [NFUNC];
    byte_t act_arr [NFUNC];
    logic  func_hit;
    byte_t func_rd;

    cfg_port_ctrl u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_en && (addr == A_PORT)),
        .wr_fields (portcfg_fields(wdata)),
        .rd_image  (port_img),
        .lsb_first (lsb_first_o),
        .soft_rst  (soft_rst_o)
    );

    cfg_xfer_ctrl u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst_o),
        .wr_hit   (wr_en && (addr == A_XFER)),
        .go       (wdata[0]),
        .commit   (commit_o)
    );

    generate
        for (genvar k = 0; k < NFUNC; k++) begin : g_func
            localparam logic [ADDR_W-1:0] A_K = ADDR_W'(FUNC_LO + k);
            cfg_func_byte #(
                .SHADOWED ((FUNC_LO + k) <= SHD_HI),
                .HAS_DEF  (k == CLK_IDX),
                .DEF_VAL  ((k == CLK_IDX) ? CLK_DEF : byte_t'(0))
            ) u_byte (
                .clk      (clk),
                .rst_n    (rst_n),
                .soft_rst (soft_rst_o),
                .wr_hit   (wr_en && (addr == A_K)),
                .wdata    (wdata),
                .commit   (commit_o),
                .shd_o    (shd_arr[k]),
                .act_o    (act_arr[k])
            );
            assign act_q[k*BYTE_W +: BYTE_W] = act_arr[k];
        end
    endgenerate

    assign dcs_en_o = act_arr[CLK_IDX][0];

    // Select the staging byte of the addressed function register.
    always_comb begin
        func_hit = 1'b0;
        func_rd  = '0;
        for (int k = 0; k < NFUNC; k++) begin
            if (addr == ADDR_W'(FUNC_LO + k)) begin
                func_hit = 1'b1;
                func_rd  = shd_arr[k];
            end
        end
    end

    // Read multiplexer; undefined addresses and idle cycles give zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == A_PORT)       rdata = port_img;
            else if (addr == A_ID)    rdata = CHIP_ID;
            else if (addr == A_GRADE) rdata = GRADE_IMG;
            else if (addr == A_XFER)  rdata = {{(BYTE_W-1){1'b0}}, commit_o};
            else if (func_hit)        rdata = func_rd;
        end
    end

    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_ID) |-> (rdata == CHIP_ID)); // R7

    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !func_hit && addr != A_PORT && addr != A_ID
         && addr != A_GRADE && addr != A_XFER) |-> (rdata == '0)); // R10

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0)); // R1

    AST_XFER_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_XFER && !commit_o) |-> (rdata == '0)); // R3

endmodule

// File: tb/cfg_shadow_bank_test.sv
`timescale 1ns/1ps
module cfg_shadow_bank_test;

    localparam int NF = 35;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic [NF*8-1:0] act_q;
    logic         dcs_en_o, lsb_first_o, soft_rst_o, commit_o;

    cfg_shadow_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .act_q(act_q),
        .dcs_en_o(dcs_en_o), .lsb_first_o(lsb_first_o),
        .soft_rst_o(soft_rst_o), .commit_o(commit_o)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    bit valid   = 0;
    string ctx  = "";

    // Reference state; -1 marks a byte not yet known.
    int   m_shd [256];
    int   m_act [256];
    logic m_l6, m_s5, m_s2, m_l1, m_x;

    function automatic bit is_func(int a);
        return a >= 8'h08 && a <= 8'h2A;
    endfunction

    function automatic string rtag(int a);
        if (a == 0) return "R5";
        if (a == 1 || a == 2) return "R7";
        if (a == 8'hFF) return "R3";
        if (a >= 8'h08 && a <= 8'h18) return "R2";
        if (is_func(a)) return "R4";
        return "R10";
    endfunction

    task automatic check(string tag, int got, int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s%s: got %0h expected %0h at %0t", tag, ctx, got, exp, $time);
        end
    endtask

    // Compare all outputs with the model for the current inputs.
    task automatic compare();
        int er;
        int bad;
        int bad_got;
        int bad_exp;
        if (!valid) return;
        er = 0;
        if (rd_en) begin
            if (addr == 0)            er = {1'b0, m_l6, m_s5, 2'b11, m_s2, m_l1, 1'b0};
            else if (addr == 1)       er = 8'h0C;
            else if (addr == 2)       er = 8'h30;
            else if (addr == 8'hFF)   er = {7'b0, m_x};
            else if (is_func(addr))   er = m_shd[addr];
        end
        if (er != -1) begin
            if (!rd_en) check("R1", rdata, er);
            else        check(rtag(addr), rdata, er);
        end
        bad = -1; bad_got = 0; bad_exp = 0;
        for (int k = 0; k < NF; k++) begin
            if (m_act[8+k] != -1 && int'(act_q[k*8 +: 8]) != m_act[8+k] && bad < 0) begin
                bad = k; bad_got = act_q[k*8 +: 8]; bad_exp = m_act[8+k];
            end
        end
        if (bad >= 0) check((bad + 8 <= 8'h18) ? "R2,R3,R9" : "R4,R9", bad_got, bad_exp);
        else          check("R9", 0, 0);
        check("R9", dcs_en_o, m_act[9] & 1);
        check("R5", lsb_first_o, m_l6 | m_l1);
        check("R6", soft_rst_o, m_s5 | m_s2);
        check("R3", commit_o, m_x);
    endtask

    // Advance the model by one clock edge.
    task automatic model_edge(logic r, logic we, logic [7:0] a, logic [7:0] d);
        int prev [256];
        bit hit;
        bit cmt;
        hit = !r || m_s5 || m_s2;
        cmt = m_x;
        prev = m_shd;
        for (int x = 8; x <= 8'h2A; x++) begin
            if (x == 9 && hit) begin
                m_shd[x] = 1; m_act[x] = 1;
            end else begin
                if (we && a == x) m_shd[x] = d;
                if (x <= 8'h18) begin
                    if (cmt) m_act[x] = prev[x];
                end else begin
                    m_act[x] = m_shd[x];
                end
            end
        end
        if (hit) begin
            {m_l6, m_s5, m_s2, m_l1} = '0;
        end else if (we && a == 0) begin
            {m_l6, m_s5, m_s2, m_l1} = {d[6], d[5], d[2], d[1]};
        end
        m_x = hit ? 1'b0 : (we && a == 8'hFF && d[0]);
        if (!r) valid = 1;
    endtask

    task automatic step(logic r, logic we, logic re, logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        rst_n = r; wr_en = we; rd_en = re; addr = a; wdata = d;
        #1 compare();
        @(posedge clk);
        model_edge(r, we, a, d);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d); step(1, 1, 0, a, d); endtask
    task automatic rd(logic [7:0] a);                 step(1, 0, 1, a, 8'h00); endtask

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 256; i++) begin m_shd[i] = -1; m_act[i] = -1; end
        {m_l6, m_s5, m_s2, m_l1, m_x} = '0;

        ctx = " (R8 reset)";
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        rd(8'h00); rd(8'h09); rd(8'hFF); rd(8'h01); rd(8'h02);

        ctx = " (R10 undefined)";
        rd(8'h05); rd(8'h2B); rd(8'h80); rd(8'hFE);

        ctx = " (R7 read-only write)";
        wr(8'h01, 8'hA5); wr(8'h02, 8'h5A); rd(8'h01); rd(8'h02);

        ctx = " (R2 fill)";
        for (int x = 8; x <= 8'h2A; x++) wr(8'(x), 8'((x * 7 + 3) & 8'hFF));
        rd(8'h08); rd(8'h18); rd(8'h20); rd(8'h2A);

        ctx = " (R3 commit)";
        wr(8'hFF, 8'h01); rd(8'hFF); rd(8'hFF);

        ctx = " (R3 no-go)";
        wr(8'h0A, 8'h99); wr(8'hFF, 8'h02); rd(8'h0A); rd(8'hFF);

        ctx = " (R3 write on commit edge)";
        wr(8'h0B, 8'h11); wr(8'hFF, 8'h81); wr(8'h0B, 8'h22); rd(8'h0B);
        wr(8'hFF, 8'h01); rd(8'h0B);

        ctx = " (R9 stabilizer off)";
        wr(8'h09, 8'h00); wr(8'hFF, 8'h01); step(1, 0, 0, 0, 0);

        ctx = " (R5 mirror)";
        wr(8'h00, 8'h40); rd(8'h00); wr(8'h00, 8'h02); rd(8'h00);
        wr(8'h00, 8'hFF); rd(8'h00);
        ctx = " (R6 soft)";
        rd(8'h00); rd(8'h09);
        wr(8'h09, 8'h00); wr(8'hFF, 8'h01); step(1, 0, 0, 0, 0);
        wr(8'h00, 8'h04); rd(8'h00); rd(8'h09);
        wr(8'h00, 8'h20); step(1, 0, 0, 0, 0); rd(8'h00);

        ctx = " (R10 undefined write)";
        wr(8'h05, 8'hFF); wr(8'hFE, 8'h01); wr(8'h2B, 8'h33);
        rd(8'h05); rd(8'hFE); rd(8'hFF);

        ctx = " (R1 idle read)";
        step(1, 0, 0, 8'h01, 8'h00); step(1, 0, 0, 8'h08, 8'h00);

        ctx = " (R8 retain)";
        wr(8'h00, 8'h42); wr(8'h09, 8'h00); wr(8'hFF, 8'h01); step(1, 0, 0, 0, 0);
        wr(8'hFF, 8'h01);
        step(0, 0, 0, 0, 0);
        rd(8'h00); rd(8'h09); rd(8'h0A); rd(8'h20); rd(8'hFF);

        ctx = " (mixed)";
        lfsr = 16'hACE1;
        for (int n = 0; n < 1500; n++) begin
            logic [7:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0:    a = 8'h00;
                3'd1:    a = 8'hFF;
                3'd2:    a = 8'(lfsr[15:8]);
                default: a = 8'(8'h08 + (lfsr[15:8] % 35));
            endcase
            if (a == 8'h00 && lfsr[3]) a = 8'h09;
            step(n % 97 == 96 ? 1'b0 : 1'b1, lfsr[4], lfsr[5], a, 8'(lfsr[13:6]));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule